// File: doc/BRIEF.md
# Real-Time Clock Update-Cycle and Update-Ended Interrupt

This block reproduces the once-per-second update cycle of a PC-style real-time clock and the interrupt raised when that update finishes. A microsecond tick advances a position counter that runs from zero to one less than the ticks per second and then wraps; the wrap is the second boundary. For a short window before each boundary the block reports update-in-progress. At the boundary it latches an update-ended flag. If that interrupt is enabled, it also latches an interrupt-request flag and drives a level interrupt.

Software reaches three registers through an index/data port pair. Control register B holds the freeze bit, which stops all update activity, and the update-ended enable. Status register A carries the update-in-progress bit and the reference divider and rate code. Flag register C is read-only and is cleared by reading it. Calendar counting, alarms, the periodic interrupt and the time/date storage are not part of this block.

Top module: `rtc_update_irq`

## Requirements
- R1: The position counter advances by one on each cycle with `us_tick` high, holds otherwise, and wraps from TICKS_PER_SEC-1 to 0. A second boundary is a tick taken while the position is TICKS_PER_SEC-1.
- R2: Register A bit 7 (update-in-progress) reads 1 exactly while the position is at least TICKS_PER_SEC-UIP_LEAD and register B bit 7 is 0. It reads 0 from the boundary onward.
- R3: At a second boundary with register B bit 7 clear, register C bit 4 (update-ended flag) becomes 1.
- R4: At such a boundary with register B bit 4 (update-ended enable) set, register C bit 7 (interrupt-request flag) becomes 1 and `irq` rises. `irq` is a level that stays high until register C is read.
- R5: A data read with the index at register C returns its current contents on `port_rdata`. The clock edge of that read clears all of register C and drops `irq`. A boundary in the same cycle sets its flags after the clear.
- R6: While register B bit 7 (freeze) is 1, update-in-progress reads 0 and a boundary sets neither flag in register C.
- R7: A write to register B that changes bit 4 from 0 to 1 while the update-ended flag is already set raises the interrupt-request flag and `irq` on that write's edge.
- R8: Clearing the freeze bit while the position is already inside the update window makes update-in-progress read 1 at once. The update then completes at the next boundary.
- R9: After reset, register A reads 0x26 (divider select 010 in bits 6:4, rate code 6), registers B and C read 0x00, and `irq` is low.
- R10: A write with `port_sel`=0 loads the index. With `port_sel`=1, a write or read goes to the indexed register: 0x0A is A, 0x0B is B, 0x0C is C. Writes to A change only bits 6:0. Writes to C are ignored. Other indices read 0x00. A read that coincides with a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| port_sel | input | 1 | 0 selects the index register, 1 the data register |
| port_wr | input | 1 | Write strobe |
| port_rd | input | 1 | Read strobe (data register only) |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data of the indexed register, valid in the cycle of the read |
| irq | output | 1 | Update-ended interrupt level |

## Verification
The bench aims at the cycles where two events meet:
- A read of register C on the very tick that ends the second. A design that let the clear win would lose that second's flag.
- Re-enabling the interrupt while the flag is already pending. A design that waited for the next boundary would deliver the interrupt up to one second late.
- Releasing the freeze bit inside the update window. A design that armed only at the window's start would miss that second's update-in-progress entirely.
- The window edges TICKS_PER_SEC-UIP_LEAD-1 and TICKS_PER_SEC-1. An off-by-one compare would show update-in-progress one microsecond early or late.

Random traffic also sets the freeze bit during boundaries. A design that still latched flags while frozen would disagree with the reference model.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
    localparam int unsigned DATA_W = 8;

    localparam logic [DATA_W-1:0] IDX_STAT = 8'h0A;
    localparam logic [DATA_W-1:0] IDX_CTRL = 8'h0B;
    localparam logic [DATA_W-1:0] IDX_FLAG = 8'h0C;

    localparam int unsigned STAT_BUSY_BIT = 7;
    localparam int unsigned CTRL_FRZ_BIT  = 7;
    localparam int unsigned CTRL_UEN_BIT  = 4;
    localparam int unsigned FLAG_REQ_BIT  = 7;
    localparam int unsigned FLAG_UPD_BIT  = 4;

    localparam logic [DATA_W-2:0] STAT_RESET = 7'h26;

    typedef struct packed {
        logic [DATA_W-2:0] stat_low;
        logic [DATA_W-1:0] ctrl;
        logic              upd_flag;
        logic              req_flag;
    } upd_state_t;
endpackage

// File: rtl/rtc_subsec_ctr.sv
module rtc_subsec_ctr #(
    parameter int unsigned TICKS_PER_SEC = 1000000,
    parameter int unsigned UIP_LEAD      = 244,
    localparam int unsigned POS_W        = $clog2(TICKS_PER_SEC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic at_boundary,
    output logic in_window
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(TICKS_PER_SEC - 1);
    localparam logic [POS_W-1:0] WIN_START = POS_W'(TICKS_PER_SEC - UIP_LEAD);

    logic [POS_W-1:0] pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (tick) begin
            pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
        at_boundary = tick && (pos_q == LAST_POS);
        in_window   = (pos_q >= WIN_START);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_boundary |=> (pos_q == '0));
    // R1
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST_POS);
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos_q));
endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
    import rtc_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_sel,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [DATA_W-1:0] port_wdata,
    output logic              data_wr,
    output logic              data_rd,
    output logic              hit_stat,
    output logic              hit_ctrl,
    output logic              hit_flag
);
    logic [DATA_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (port_wr && !port_sel) idx_d = port_wdata;
        data_wr  = port_wr && port_sel;
        data_rd  = port_rd && port_sel && !port_wr;
        hit_stat = (idx_q == IDX_STAT);
        hit_ctrl = (idx_q == IDX_CTRL);
        hit_flag = (idx_q == IDX_FLAG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    // R10
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_wr && !port_sel) |=> $stable(idx_q));
    // R10
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_stat, hit_ctrl, hit_flag}));
endmodule

// File: rtl/rtc_upd_regs.sv
module rtc_upd_regs
    import rtc_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              at_boundary,
    input  logic              in_window,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              hit_stat,
    input  logic              hit_ctrl,
    input  logic              hit_flag,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    upd_state_t st_d, st_q;
    logic frozen, uen, busy;

    always_comb begin
        st_d   = st_q;
        frozen = st_q.ctrl[CTRL_FRZ_BIT];
        uen    = st_q.ctrl[CTRL_UEN_BIT];
        busy   = in_window && !frozen;

        rdata = '0;
        if (hit_stat) begin
            rdata = {busy, st_q.stat_low};
        end else if (hit_ctrl) begin
            rdata = st_q.ctrl;
        end else if (hit_flag) begin
            rdata[FLAG_REQ_BIT] = st_q.req_flag;
            rdata[FLAG_UPD_BIT] = st_q.upd_flag;
        end

        if (data_wr && hit_stat) st_d.stat_low = wdata[DATA_W-2:0];
        if (data_wr && hit_ctrl) begin
            st_d.ctrl = wdata;
            if (wdata[CTRL_UEN_BIT] && !uen && st_q.upd_flag) st_d.req_flag = 1'b1;
        end
        if (data_rd && hit_flag) begin
            st_d.upd_flag = 1'b0;
            st_d.req_flag = 1'b0;
        end
        if (at_boundary && !frozen) begin
            st_d.upd_flag = 1'b1;
            if (uen) st_d.req_flag = 1'b1;
        end
        irq = st_q.req_flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.stat_low <= STAT_RESET;
            st_q.ctrl     <= '0;
            st_q.upd_flag <= 1'b0;
            st_q.req_flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    flag_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_boundary && !frozen |=> st_q.upd_flag);
    // R4
    irq_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_boundary && !frozen && uen |=> irq);
    // R4
    irq_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(data_rd && hit_flag) |=> irq);
    // R5
    flag_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && hit_flag && !at_boundary |=> !st_q.upd_flag && !irq);
    // R6
    freeze_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_boundary && frozen && !st_q.upd_flag |=> !st_q.upd_flag);
    // R7
    late_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && hit_ctrl && wdata[CTRL_UEN_BIT] && !uen && st_q.upd_flag |=> irq);
endmodule

// File: rtl/rtc_update_irq.sv
module rtc_update_irq
    import rtc_upd_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 1000000,
    parameter int unsigned UIP_LEAD      = 244
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              port_sel,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [DATA_W-1:0] port_wdata,
    output logic [DATA_W-1:0] port_rdata,
    output logic              irq
);
    logic at_boundary, in_window;
    logic data_wr, data_rd, hit_stat, hit_ctrl, hit_flag;

    rtc_subsec_ctr #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .UIP_LEAD     (UIP_LEAD)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (us_tick),
        .at_boundary(at_boundary),
        .in_window  (in_window)
    );

    rtc_index_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_sel  (port_sel),
        .port_wr   (port_wr),
        .port_rd   (port_rd),
        .port_wdata(port_wdata),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .hit_stat  (hit_stat),
        .hit_ctrl  (hit_ctrl),
        .hit_flag  (hit_flag)
    );

    rtc_upd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .at_boundary(at_boundary),
        .in_window  (in_window),
        .data_wr    (data_wr),
        .data_rd    (data_rd),
        .hit_stat   (hit_stat),
        .hit_ctrl   (hit_ctrl),
        .hit_flag   (hit_flag),
        .wdata      (port_wdata),
        .rdata      (port_rdata),
        .irq        (irq)
    );
endmodule

// File: tb/rtc_update_irq_test.sv
module rtc_update_irq_test;
    localparam int unsigned TPS  = 200;
    localparam int unsigned LEAD = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, us_tick, port_sel, port_wr, port_rd;
    logic [7:0] port_wdata;
    logic [7:0] port_rdata;
    logic       irq;

    rtc_update_irq #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .port_sel(port_sel),
        .port_wr(port_wr), .port_rd(port_rd), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int         m_pos;
    logic [7:0] m_idx, m_b;
    logic [6:0] m_alow;
    logic       m_uf, m_irqf;

    function automatic logic [7:0] exp_read();
        logic [7:0] v = 8'h00;
        if (m_idx == 8'h0A) v = {(!m_b[7] && m_pos >= int'(TPS - LEAD)), m_alow};
        else if (m_idx == 8'h0B) v = m_b;
        else if (m_idx == 8'h0C) v = {m_irqf, 2'b00, m_uf, 4'b0000};
        return v;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h (pos %0d)", req, act, exp, m_pos);
        end
    endtask

    task automatic model_reset();
        m_pos = 0; m_idx = 8'h00; m_b = 8'h00; m_alow = 7'h26; m_uf = 1'b0; m_irqf = 1'b0;
    endtask

    task automatic cyc(input logic tk, input logic wr, input logic rd, input logic sel,
                       input logic [7:0] wd, input string req);
        logic bnd, hit_a, hit_b, hit_c, nuf, nirq;
        @(negedge clk);
        check8("R4 irq level", {7'b0, irq}, {7'b0, m_irqf});
        us_tick = tk; port_wr = wr; port_rd = rd; port_sel = sel; port_wdata = wd;
        #1;
        if (rd && sel && !wr) check8(req, port_rdata, exp_read());
        @(posedge clk);
        bnd   = tk && (m_pos == int'(TPS - 1));
        hit_a = (m_idx == 8'h0A); hit_b = (m_idx == 8'h0B); hit_c = (m_idx == 8'h0C);
        nuf = m_uf; nirq = m_irqf;
        if (wr && sel && hit_a) m_alow = wd[6:0];
        if (wr && sel && hit_b) begin
            if (wd[4] && !m_b[4] && m_uf) nirq = 1'b1;
        end
        if (rd && sel && !wr && hit_c) begin nuf = 1'b0; nirq = 1'b0; end
        if (bnd && !m_b[7]) begin nuf = 1'b1; if (m_b[4]) nirq = 1'b1; end
        if (wr && sel && hit_b) m_b = wd;
        if (wr && !sel) m_idx = wd;
        if (tk) m_pos = bnd ? 0 : m_pos + 1;
        m_uf = nuf; m_irqf = nirq;
    endtask

    task automatic set_idx(input logic [7:0] v); cyc(0, 1, 0, 0, v, "R10"); endtask
    task automatic rd_data(input string req); cyc(0, 0, 1, 1, 8'h00, req); endtask
    task automatic wr_data(input logic [7:0] v, input string req); cyc(0, 1, 0, 1, v, req); endtask
    task automatic tick_until(input int p);
        while (m_pos != p) cyc(1, 0, 0, 0, 8'h00, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; us_tick = 0; port_wr = 0; port_rd = 0; port_sel = 0; port_wdata = 0;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R9 reset values
        set_idx(8'h0A); rd_data("R9 reg A");
        set_idx(8'h0B); rd_data("R9 reg B");
        set_idx(8'h0C); rd_data("R9 reg C");

        // R2 window edges
        set_idx(8'h0A);
        tick_until(TPS - LEAD - 1); rd_data("R2 before window");
        cyc(1, 0, 0, 0, 8'h00, "R1"); rd_data("R2 window start");
        tick_until(TPS - 1); rd_data("R2 last position");
        cyc(1, 0, 0, 0, 8'h00, "R1"); rd_data("R2 after boundary");

        // R3 flag latched, no irq while disabled
        set_idx(8'h0C); rd_data("R3 flag set"); rd_data("R5 cleared");

        // R4 enabled boundary, level held
        set_idx(8'h0B); wr_data(8'h10, "R4");
        tick_until(TPS - 1); cyc(1, 0, 0, 0, 8'h00, "R4");
        repeat (5) cyc(0, 0, 0, 0, 8'h00, "R4");
        set_idx(8'h0C); rd_data("R4 flags"); rd_data("R5 cleared");

        // R6 freeze
        set_idx(8'h0B); wr_data(8'h90, "R6");
        set_idx(8'h0A); tick_until(TPS - 3); rd_data("R6 no busy");
        tick_until(0); set_idx(8'h0C); rd_data("R6 no flags");

        // R8 unfreeze inside window
        tick_until(TPS - 5);
        set_idx(8'h0B); wr_data(8'h10, "R8");
        set_idx(8'h0A); rd_data("R8 busy at once");
        tick_until(0); set_idx(8'h0C); rd_data("R8 completes");

        // R7 late enable with pending flag
        set_idx(8'h0B); wr_data(8'h00, "R7");
        tick_until(TPS - 1); cyc(1, 0, 0, 0, 8'h00, "R7");
        wr_data(8'h10, "R7 enable");
        cyc(0, 0, 0, 0, 8'h00, "R7");
        set_idx(8'h0C); rd_data("R7 flags");

        // R5 read of C on the boundary tick
        tick_until(TPS - 1);
        cyc(1, 0, 1, 1, 8'h00, "R5 read on boundary");
        rd_data("R5 flag survives");

        // R10 port rules
        wr_data(8'hFF, "R10 C write"); rd_data("R10 C unchanged");
        set_idx(8'h0A); wr_data(8'hFF, "R10"); rd_data("R10 A bit7 read-only");
        set_idx(8'h0D); rd_data("R10 unmapped");
        set_idx(8'h0B); cyc(0, 1, 1, 1, 8'h00, "R10 read with write");
        rd_data("R10 B written");

        // random traffic
        for (int i = 0; i < 20000; i++) begin
            int r = int'($urandom % 100);
            logic tk = ($urandom % 4) != 0;
            logic [7:0] wd = 8'($urandom);
            if (r < 65) cyc(tk, 0, 0, 0, 8'h00, "R1");
            else if (r < 80) cyc(tk, 0, 1, 1, 8'h00, "R2/R5 random read");
            else if (r < 86) begin
                logic [7:0] ix = 8'h0A + 8'($urandom % 4);
                cyc(tk, 1, 0, 0, ix, "R10");
            end else begin
                if (($urandom % 8) != 0) wd[7] = 1'b0;
                cyc(tk, 1, 0, 1, wd, "R7/R6 random write");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule